// File: doc/BRIEF.md
# Data-Strobe Line Codec

This block sends and receives a serial bit stream over two wires, a Data wire and a Strobe wire. The transmit half accepts one bit at a time through a valid/ready handshake. It puts the bit value on the Data wire unchanged. It flips the Strobe wire only when the new bit repeats the one before it. On every bit exactly one of the two wires moves, so the XOR of the pair toggles once per bit and carries the timing.

The receive half samples both incoming wires on a local clock that runs at least four times the bit rate. Each wire first passes through a two-stage synchronizer. A change on exactly one wire marks a new bit: the receiver reads that bit from the Data wire, pulses a valid strobe and updates a recovered bit clock equal to the XOR of the two wires. A sample in which both wires change at once is reported as a line error and yields no bit. Because a bit boundary is marked by whichever wire moves, the pair tolerates skew between the wires of almost a whole bit period.

Both halves share one clock domain and one active-low asynchronous reset. In a loopback they can be tied together directly, or each can face a remote partner.

Top module: `ds_link_codec`

## Requirements
- R1: After reset, the transmit wires are both 0, tx_ready is 1, and rx_valid, rx_err and rx_clk are 0.
- R2: The cycle after a bit is accepted (tx_valid and tx_ready both high at a clock edge), ds_data_o equals that bit.
- R3: On each accepted bit, ds_strobe_o inverts if and only if the bit equals the value ds_data_o held just before. The reset value 0 counts as that previous value for the first bit.
- R4: Each accepted bit changes exactly one of ds_data_o and ds_strobe_o.
- R5: When the last accepted bit has an even index (the first bit after reset is index 0), ds_strobe_o equals the inverse of ds_data_o. When that index is odd, or no bit has been sent yet, ds_strobe_o equals ds_data_o.
- R6: After each accepted bit, tx_ready stays low for BIT_CYCLES-1 cycles and both transmit wires hold their values. A new bit can therefore be taken every BIT_CYCLES cycles.
- R7: With the transmit wires looped to the receive wires, the receiver delivers every sent bit on rx_bit, in order, with a one-cycle rx_valid pulse per bit and no extra pulses.
- R8: rx_clk equals the XOR of the synchronized receive wires. It toggles exactly once with each rx_valid pulse.
- R9: When both synchronized receive wires change in the same sample, rx_err pulses for one cycle, no rx_valid is produced for that sample, and rx_clk does not change.
- R10: Delaying either receive wire relative to the other by up to BIT_CYCLES-1 cycles does not change the received bit sequence.
- R11: While no bit is offered, both transmit wires stay constant and the receiver produces no rx_valid and no rx_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, at least four times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A bit is offered on tx_bit |
| tx_bit | input | 1 | Bit value to send |
| tx_ready | output | 1 | Encoder can take a bit this cycle |
| ds_data_o | output | 1 | Transmit Data wire |
| ds_strobe_o | output | 1 | Transmit Strobe wire |
| ds_data_i | input | 1 | Receive Data wire (asynchronous) |
| ds_strobe_i | input | 1 | Receive Strobe wire (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: rx_bit holds a new bit |
| rx_bit | output | 1 | Most recently recovered bit |
| rx_clk | output | 1 | Recovered bit clock, XOR of the synchronized wires |
| rx_err | output | 1 | One-cycle pulse: both wires changed in one sample |

## Verification
Every cycle, the embedded properties check four things. Each accepted bit moves exactly one transmit wire and flips Strobe under the repeat rule. The parity relation between the two wires holds. The handshake stays closed for the hold window. On the receive side, every valid pulse comes with a toggle of rx_clk and with the bit taken from the synchronized Data wire, and every error sample leaves rx_clk unchanged. Some properties span both halves, and only the bench's scenarios can show them. These are that the exact bit sequence survives the loopback under alternating patterns, long runs and pseudo-random data; that it also survives a delay of nearly a bit period on either wire; that an injected simultaneous flip of both wires costs no bit; and that an idle link stays silent.

// File: rtl/ds_codec_pkg.sv
package ds_codec_pkg;

    // One sample of the two-wire pair; data is the upper bit when packed.
    typedef struct packed {
        logic data;
        logic strobe;
    } ds_pair_t;

    // Receive-side registered state.
    typedef struct packed {
        ds_pair_t prev;     // synchronized pair seen on the previous cycle
        logic     valid;    // new bit pulse
        logic     bit_v;    // last recovered bit
        logic     rclk;     // recovered bit clock
        logic     err;      // double-change pulse
    } ds_dec_state_t;

endpackage

// File: rtl/ds_encoder.sv
module ds_encoder
    import ds_codec_pkg::*;
#(
    parameter int BIT_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_bit,
    output logic     in_ready,
    output ds_pair_t line
);

    localparam int HOLD_W = $clog2(BIT_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(BIT_CYCLES - 1);

    typedef struct packed {
        ds_pair_t          line;
        logic              last_even;   // index of the last sent bit is even
        logic [HOLD_W-1:0] hold;        // cycles left before the next bit
    } enc_state_t;

    localparam enc_state_t ENC_RESET = '{line: '{data: 1'b0, strobe: 1'b0},
                                         last_even: 1'b0,
                                         hold: '0};

    enc_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = in_valid && (st_q.hold == '0);
        if (accept) begin
            st_d.line.data   = in_bit;
            st_d.line.strobe = st_q.line.strobe ^ (in_bit == st_q.line.data);
            st_d.last_even   = ~st_q.last_even;
            st_d.hold        = HOLD_LOAD;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENC_RESET;
        else        st_q <= st_d;
    end

    assign in_ready = (st_q.hold == '0);
    assign line     = st_q.line;

    // R3
    strobe_repeat_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((line.strobe != $past(line.strobe)) ==
                    ($past(in_bit) == $past(line.data))));

    // R4
    one_wire_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((line.data != $past(line.data)) != (line.strobe != $past(line.strobe))));

    // R5
    parity_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line.strobe == (line.data ^ st_q.last_even));

    // R6
    hold_closes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R6
    idle_lines_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(line.data) && $stable(line.strobe)));

endmodule

// File: rtl/ds_sync.sv
module ds_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ds_decoder.sv
module ds_decoder
    import ds_codec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ds_pair_t line_s,
    output logic     out_valid,
    output logic     out_bit,
    output logic     out_clk,
    output logic     out_err
);

    localparam ds_dec_state_t DEC_RESET = '{prev: '{data: 1'b0, strobe: 1'b0},
                                            valid: 1'b0, bit_v: 1'b0,
                                            rclk: 1'b0, err: 1'b0};

    ds_dec_state_t st_d, st_q;
    logic          data_moved, strobe_moved;

    always_comb begin
        data_moved   = line_s.data   ^ st_q.prev.data;
        strobe_moved = line_s.strobe ^ st_q.prev.strobe;
        st_d         = st_q;
        st_d.prev    = line_s;
        st_d.valid   = data_moved ^ strobe_moved;
        st_d.err     = data_moved & strobe_moved;
        st_d.rclk    = line_s.data ^ line_s.strobe;
        if (data_moved ^ strobe_moved) begin
            st_d.bit_v = line_s.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_RESET;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_bit   = st_q.bit_v;
    assign out_clk   = st_q.rclk;
    assign out_err   = st_q.err;

    // R8
    clk_toggles_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_clk != $past(out_clk)));

    // R7
    bit_from_data_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == $past(line_s.data)));

    // R9
    err_keeps_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $stable(out_clk));

endmodule

// File: rtl/ds_link_codec.sv
module ds_link_codec
    import ds_codec_pkg::*;
#(
    parameter int BIT_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_ready,
    output logic ds_data_o,
    output logic ds_strobe_o,
    input  logic ds_data_i,
    input  logic ds_strobe_i,
    output logic rx_valid,
    output logic rx_bit,
    output logic rx_clk,
    output logic rx_err
);

    localparam int PAIR_W = $bits(ds_pair_t);

    ds_pair_t          tx_line;
    ds_pair_t          rx_line_s;
    logic [PAIR_W-1:0] rx_raw, rx_synced;

    ds_encoder #(.BIT_CYCLES(BIT_CYCLES)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_bit   (tx_bit),
        .in_ready (tx_ready),
        .line     (tx_line)
    );

    assign ds_data_o   = tx_line.data;
    assign ds_strobe_o = tx_line.strobe;

    assign rx_raw = {ds_data_i, ds_strobe_i};

    ds_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_raw),
        .dout  (rx_synced)
    );

    assign rx_line_s = ds_pair_t'(rx_synced);

    ds_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (rx_line_s),
        .out_valid (rx_valid),
        .out_bit   (rx_bit),
        .out_clk   (rx_clk),
        .out_err   (rx_err)
    );

    // R9
    no_bit_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !rx_valid);

endmodule

// File: tb/sim_ds_link_codec.sv
module sim_ds_link_codec;

    localparam int BC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_bit = 1'b0;
    logic tx_ready, ds_data_o, ds_strobe_o;
    logic ds_data_i, ds_strobe_i;
    logic rx_valid, rx_bit, rx_clk, rx_err;

    always #5 clk = ~clk;

    // Channel model: optional per-wire delay and a forced override.
    int   sk_d = 0, sk_s = 0;
    logic inj = 1'b0, inj_d = 1'b0, inj_s = 1'b0;
    logic [7:0] hist_d = '0, hist_s = '0;

    always @(posedge clk) begin
        hist_d <= {hist_d[6:0], ds_data_o};
        hist_s <= {hist_s[6:0], ds_strobe_o};
    end

    assign ds_data_i   = inj ? inj_d : ((sk_d == 0) ? ds_data_o   : hist_d[sk_d-1]);
    assign ds_strobe_i = inj ? inj_s : ((sk_s == 0) ? ds_strobe_o : hist_s[sk_s-1]);

    ds_link_codec #(.BIT_CYCLES(BC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
        .ds_data_o(ds_data_o), .ds_strobe_o(ds_strobe_o),
        .ds_data_i(ds_data_i), .ds_strobe_i(ds_strobe_i),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_clk(rx_clk), .rx_err(rx_err)
    );

    int checks = 0, errors = 0;
    int valids = 0, errs_seen = 0;
    int bit_idx = 0;
    logic err_allowed = 1'b0;
    logic exp_clk = 1'b0;
    logic exp_q[$];
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard for the receive side.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                valids++;
                exp_clk = ~exp_clk;
                chk(rx_clk == exp_clk, "R8 rx_clk toggle", rx_clk, exp_clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected bit", rx_bit, -1);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(rx_bit == e, "R7/R10 bit order", rx_bit, e);
                end
            end
            if (rx_err) begin
                errs_seen++;
                if (!err_allowed) chk(1'b0, "R11 spurious rx_err", 1, 0);
            end
        end
    end

    // Driver: offers one bit, checks the transmit wires, queues the expected bit.
    task automatic send(input logic b);
        logic pd;
        logic ps;
        int lows;
        while (!tx_ready) @(negedge clk);
        pd = ds_data_o;
        ps = ds_strobe_o;
        exp_q.push_back(b);
        tx_valid = 1'b1;
        tx_bit   = b;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(ds_data_o == b, "R2 data wire", ds_data_o, b);
        chk((ds_strobe_o != ps) == (b == pd), "R3 strobe rule", ds_strobe_o, ps ^ (b == pd));
        chk((ds_data_o != pd) != (ds_strobe_o != ps), "R4 one wire", {ds_data_o, ds_strobe_o}, {pd, ps});
        chk(ds_strobe_o == (ds_data_o ^ ((bit_idx % 2) == 0)), "R5 parity", ds_strobe_o,
            ds_data_o ^ ((bit_idx % 2) == 0));
        bit_idx++;
        lows = 0;
        pd = ds_data_o;
        ps = ds_strobe_o;
        while (!tx_ready) begin
            lows++;
            if (ds_data_o != pd || ds_strobe_o != ps) chk(1'b0, "R6 wires moved in hold", 1, 0);
            @(negedge clk);
        end
        chk(lows == BC - 1, "R6 ready low cycles", lows, BC - 1);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all bits received", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        int v0, snapshot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ds_data_o == 0 && ds_strobe_o == 0, "R1 tx wires", {ds_data_o, ds_strobe_o}, 0);
        chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
        chk(rx_valid == 0 && rx_err == 0 && rx_clk == 0, "R1 rx outputs",
            {rx_valid, rx_err, rx_clk}, 0);

        // First bit 0, then alternating.
        for (int i = 0; i < 16; i++) send(i[0]);
        drain();
        // Long runs of ones then zeros.
        for (int i = 0; i < 10; i++) send(1'b1);
        for (int i = 0; i < 10; i++) send(1'b0);
        drain();
        // Pseudo-random stream.
        lfsr = 8'hA5;
        for (int i = 0; i < 60; i++) begin
            send(lfsr[0]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        drain();

        // R11: idle link.
        snapshot = valids;
        v0 = {ds_data_o, ds_strobe_o};
        repeat (20) @(negedge clk);
        chk({ds_data_o, ds_strobe_o} == v0, "R11 idle wires", {ds_data_o, ds_strobe_o}, v0);
        chk(valids == snapshot, "R11 idle no rx_valid", valids, snapshot);
        chk(rx_clk == (ds_data_o ^ ds_strobe_o), "R8 idle rx_clk", rx_clk, ds_data_o ^ ds_strobe_o);

        // R10: strobe wire late by BC-1 cycles.
        sk_s = BC - 1;
        for (int i = 0; i < 30; i++) begin
            send(lfsr[1]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        for (int i = 0; i < 6; i++) send(1'b1);
        drain();
        sk_s = 0;
        // R10: data wire late by BC-1 cycles.
        sk_d = BC - 1;
        for (int i = 0; i < 30; i++) begin
            send(lfsr[2]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        for (int i = 0; i < 6; i++) send(1'b0);
        drain();
        sk_d = 0;
        repeat (12) @(negedge clk);

        // R9: both wires flip in one sample, then flip back.
        snapshot  = valids;
        err_allowed = 1'b1;
        inj_d = ~ds_data_o;
        inj_s = ~ds_strobe_o;
        inj   = 1'b1;
        repeat (8) @(negedge clk);
        chk(errs_seen == 1, "R9 error pulse", errs_seen, 1);
        inj_d = ds_data_o;
        inj_s = ds_strobe_o;
        repeat (8) @(negedge clk);
        inj = 1'b0;
        repeat (4) @(negedge clk);
        chk(errs_seen == 2, "R9 error count", errs_seen, 2);
        chk(valids == snapshot, "R9 no bit on error", valids, snapshot);
        chk(rx_clk == exp_clk, "R9 rx_clk unchanged", rx_clk, exp_clk);
        err_allowed = 1'b0;

        // Link still works after the error.
        for (int i = 0; i < 8; i++) send(i[1]);
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule